// File: doc/BRIEF.md
# Two-Context Register Set Switcher

This block keeps two complete banks of sensor control registers, called context A and context B, and decides which bank drives the downstream timing and gain logic. A host writes either bank at any time through a simple write port. A single select input names the wanted context. The move to a new context is staged across frame boundaries. The early group of registers (the exposure integration times) follows the new context at the first frame start after the request. Every other register follows one frame later. This keeps the exposure of a frame consistent with the readout settings that apply to it.

The effective values are held in a shadow set that only reloads on a frame-start pulse. A write therefore never changes the outputs in the middle of a frame. The select input is sampled only while readout is active. A change made while readout is idle waits until readout resumes. Two outputs report the context applied to the early group and the context applied to all the other registers.

Top module: `ctx_switch_top`

## Requirements
- R1: After a synchronous active-low reset, both banks and all effective outputs are zero, and both context outputs read context A (0).
- R2: A write (`wr_bank` 0 = A, 1 = B, register index `wr_addr`) updates only the stored bank entry. No effective output changes before the next frame start, whichever bank is written. An index of `N_REGS` or more is discarded.
- R3: On each frame-start pulse, every effective register reloads from the bank its context selects. A write to the applied bank therefore becomes visible at the next frame start.
- R4: When the sampled select differs from the early context at a frame start, the early group (register indices below `EARLY_CNT`, packed LSB-first at index × `DATA_W` in `eff_regs`) takes the new context at that frame start.
- R5: The remaining registers and `active_ctx` take the new context at the following frame start, provided the request is still the same.
- R6: A switch from B back to A is staged exactly like a switch from A to B.
- R7: If the request changes again before the staging completes, the newest request wins. The non-early registers never take up the abandoned context.
- R8: The select input is sampled only while `readout_active` is 1. A change made while it is 0 takes effect through the staging only after readout resumes.
- R9: Between frame-start pulses, the effective values and both context outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register banks |
| wr_bank | input | 1 | Target bank of a write: 0 = A, 1 = B |
| wr_addr | input | ADDR_W | Register index of a write |
| wr_data | input | DATA_W | Write data |
| ctx_sel | input | 1 | Requested context: 0 = A, 1 = B |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| readout_active | input | 1 | High while a frame is being read out; gates sampling of ctx_sel |
| eff_regs | output | N_REGS*DATA_W | Effective register values, register i at bits i*DATA_W upward |
| early_ctx | output | 1 | Context applied to the integration-time group |
| active_ctx | output | 1 | Context applied to all other registers |

## Verification
A wrong staging state shows up at the first frame-start pulse after the error. In that case, either the integration-time fields of `eff_regs` or the remaining fields come from the wrong bank, and `early_ctx` or `active_ctx` disagrees with the two-frame schedule. A corrupted bank entry stays hidden until a frame start reloads that register from its bank. A shadow register that changes outside a frame start is visible in the same cycle. The bench loads distinct patterns into the two banks, so any mix-up of banks or indices changes a compared field.

// File: rtl/ctx_switch_pkg.sv
// Shared types for the two-context register switcher.
// Assumes context A is encoded as 0 and context B as 1.
package ctx_switch_pkg;
    typedef enum logic {
        CTX_A = 1'b0,
        CTX_B = 1'b1
    } ctx_e;
endpackage

// File: rtl/ctx_bank_store.sv
// Holds the two register banks and exposes both in full.
// Assumes that a write to an index of N_REGS or more is discarded.
module ctx_bank_store #(
    parameter int N_REGS = 24,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [N_REGS*DATA_W-1:0] bank_a,
    output logic [N_REGS*DATA_W-1:0] bank_b
);
    localparam int NBANK = 2;

    logic [DATA_W-1:0] mem [NBANK][N_REGS];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar r = 0; r < N_REGS; r++) begin : g_reg
            // Stores one entry when it is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[b][r] <= '0;
                else if (wr_en && (wr_bank == 1'(b)) && (32'(wr_addr) == r))
                    mem[b][r] <= wr_data;
            end
        end
    end

    for (genvar r = 0; r < N_REGS; r++) begin : g_flat
        assign bank_a[r*DATA_W +: DATA_W] = mem[0][r];
        assign bank_b[r*DATA_W +: DATA_W] = mem[1][r];
    end
endmodule

// File: rtl/ctx_stage_ctrl.sv
// Stages the context change: the early group follows the sampled request
// at a frame start. The other registers follow one frame later, and only
// if the request has not moved again in between.
// Assumes frame_start is a single-cycle pulse.
module ctx_stage_ctrl
    import ctx_switch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctx_sel,
    input  logic frame_start,
    input  logic readout_active,
    output ctx_e early_nxt,
    output ctx_e active_nxt,
    output ctx_e early_q,
    output ctx_e active_q
);
    ctx_e req_q;

    // Samples the requested context only while readout runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= CTX_A;
        else if (readout_active)
            req_q <= ctx_e'(ctx_sel);
    end

    // Works out the contexts that apply after this cycle.
    always_comb begin
        early_nxt  = early_q;
        active_nxt = active_q;
        if (frame_start) begin
            early_nxt = req_q;
            if (early_q == req_q)
                active_nxt = early_q;
        end
    end

    // Holds the applied contexts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q  <= CTX_A;
            active_q <= CTX_A;
        end else begin
            early_q  <= early_nxt;
            active_q <= active_nxt;
        end
    end
endmodule

// File: rtl/ctx_shadow_out.sv
// Effective register shadows. At a frame start, each one reloads from the
// bank its group's next context selects.
// Assumes indices below EARLY_CNT form the integration-time group.
module ctx_shadow_out
    import ctx_switch_pkg::*;
#(
    parameter int N_REGS    = 24,
    parameter int DATA_W    = 16,
    parameter int EARLY_CNT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  ctx_e                     early_nxt,
    input  ctx_e                     active_nxt,
    input  logic [N_REGS*DATA_W-1:0] bank_a,
    input  logic [N_REGS*DATA_W-1:0] bank_b,
    output logic [N_REGS*DATA_W-1:0] eff
);
    for (genvar r = 0; r < N_REGS; r++) begin : g_sh
        ctx_e use_ctx;
        if (r < EARLY_CNT) begin : g_early
            assign use_ctx = early_nxt;
        end else begin : g_late
            assign use_ctx = active_nxt;
        end

        // Reloads this shadow at a frame start.
        always_ff @(posedge clk) begin
            if (!rst_n)
                eff[r*DATA_W +: DATA_W] <= '0;
            else if (load)
                eff[r*DATA_W +: DATA_W] <= (use_ctx == CTX_B) ?
                    bank_b[r*DATA_W +: DATA_W] : bank_a[r*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/ctx_switch_top.sv
// Top of the two-context register switcher: banks, staging control and
// effective shadows. Assumes the same clock domain for writes and frames.
module ctx_switch_top
    import ctx_switch_pkg::*;
#(
    parameter int N_REGS    = 24,
    parameter int DATA_W    = 16,
    parameter int EARLY_CNT = 2,
    parameter int ADDR_W    = $clog2(N_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     ctx_sel,
    input  logic                     frame_start,
    input  logic                     readout_active,
    output logic [N_REGS*DATA_W-1:0] eff_regs,
    output logic                     early_ctx,
    output logic                     active_ctx
);
    logic [N_REGS*DATA_W-1:0] bank_a;
    logic [N_REGS*DATA_W-1:0] bank_b;
    ctx_e early_nxt, active_nxt, early_q, active_q;

    ctx_bank_store #(.N_REGS(N_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_a  (bank_a),
        .bank_b  (bank_b)
    );

    ctx_stage_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctx_sel        (ctx_sel),
        .frame_start    (frame_start),
        .readout_active (readout_active),
        .early_nxt      (early_nxt),
        .active_nxt     (active_nxt),
        .early_q        (early_q),
        .active_q       (active_q)
    );

    ctx_shadow_out #(.N_REGS(N_REGS), .DATA_W(DATA_W), .EARLY_CNT(EARLY_CNT)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (frame_start),
        .early_nxt  (early_nxt),
        .active_nxt (active_nxt),
        .bank_a     (bank_a),
        .bank_b     (bank_b),
        .eff        (eff_regs)
    );

    assign early_ctx  = early_q;
    assign active_ctx = active_q;
endmodule

// File: rtl/ctx_switch_chk.sv
// Checker for the switcher's staging and hold rules, attached by bind.
// Assumes it observes the top ports and the sampled request.
module ctx_switch_chk #(
    parameter int N_REGS = 24,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_start,
    input logic                     readout_active,
    input logic                     req_ctx,
    input logic [N_REGS*DATA_W-1:0] eff_regs,
    input logic                     early_ctx,
    input logic                     active_ctx
);
    // R1: reset returns both contexts to A
    p_reset_ctx_r1: assert property (@(posedge clk)
        !rst_n |=> (early_ctx == 1'b0 && active_ctx == 1'b0));

    // R9: no change between frame starts
    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(eff_regs) && $stable(early_ctx) && $stable(active_ctx)));

    // R4: the early group takes the sampled request at a frame start
    p_early_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (early_ctx == $past(req_ctx)));

    // R5: the other registers only ever move to the early context
    p_late_from_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (active_ctx == $past(active_ctx) || active_ctx == $past(early_ctx)));

    // R7: a request that moved again blocks the late group
    p_newest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && req_ctx != early_ctx) |=> $stable(active_ctx));

    // R8: the request is frozen while readout is idle
    p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !readout_active |=> $stable(req_ctx));
endmodule

bind ctx_switch_top ctx_switch_chk #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .readout_active (readout_active),
    .req_ctx        (u_ctrl.req_q),
    .eff_regs       (eff_regs),
    .early_ctx      (early_ctx),
    .active_ctx     (active_ctx)
);

// File: tb/test_ctx_switch_top.sv
module test_ctx_switch_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_REGS     = 24;
    localparam int DATA_W     = 16;
    localparam int EARLY_CNT  = 2;
    localparam int ADDR_W     = $clog2(N_REGS);
    localparam int VW         = N_REGS * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_bank = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ctx_sel = 1'b0;
    logic              frame_start = 1'b0;
    logic              readout_active = 1'b0;
    logic [VW-1:0]     eff_regs;
    logic              early_ctx;
    logic              active_ctx;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic [DATA_W-1:0] mbank [2][N_REGS];
    logic [VW-1:0]     meff;
    logic              msel, mrd, mreq, mit, mact;

    // Scoreboard queues
    logic [VW-1:0] q_eff [$];
    logic          q_e   [$];
    logic          q_a   [$];
    string         q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_switch_top #(.N_REGS(N_REGS), .DATA_W(DATA_W), .EARLY_CNT(EARLY_CNT)) i_ctx_switch_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctx_sel(ctx_sel), .frame_start(frame_start),
        .readout_active(readout_active), .eff_regs(eff_regs),
        .early_ctx(early_ctx), .active_ctx(active_ctx)
    );

    task automatic push_exp(input string tag);
        q_eff.push_back(meff);
        q_e.push_back(mit);
        q_a.push_back(mact);
        q_tag.push_back(tag);
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < N_REGS; r++) mbank[b][r] = '0;
        meff = '0; mreq = 1'b0; mit = 1'b0; mact = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; ctx_sel = 1'b0; msel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1 push_exp(tag);
    endtask

    task automatic do_write(input logic b, input int a, input logic [DATA_W-1:0] d,
                            input bit chk, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < N_REGS) mbank[b][a] = d;
        if (chk) #1 push_exp(tag);
    endtask

    task automatic set_sel(input logic v);
        @(negedge clk);
        ctx_sel = v; msel = v;
        repeat (2) @(negedge clk);
        if (mrd) mreq = v;
    endtask

    task automatic set_rd(input logic v);
        @(negedge clk);
        readout_active = v; mrd = v;
        repeat (2) @(negedge clk);
        if (v) mreq = msel;
    endtask

    task automatic do_frame(input string tag);
        logic nit, nact;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        nit  = mreq;
        nact = (mit == mreq) ? mit : mact;
        mit  = nit;
        mact = nact;
        for (int r = 0; r < N_REGS; r++)
            meff[r*DATA_W +: DATA_W] = mbank[(r < EARLY_CNT) ? mit : mact][r];
        #1 push_exp(tag);
    endtask

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            while (q_tag.size() > 0) begin
                logic [VW-1:0] xe;
                logic ee, ea;
                string tg;
                xe = q_eff.pop_front(); ee = q_e.pop_front();
                ea = q_a.pop_front(); tg = q_tag.pop_front();
                n_checks++;
                if (eff_regs !== xe) begin
                    n_fail++;
                    $display("FAIL %s eff_regs got %h exp %h", tg, eff_regs, xe);
                end
                n_checks++;
                if (early_ctx !== ee || active_ctx !== ea) begin
                    n_fail++;
                    $display("FAIL %s ctx got e%0b a%0b exp e%0b a%0b",
                             tg, early_ctx, active_ctx, ee, ea);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Driver
    initial begin
        msel = 1'b0; mrd = 1'b0;
        model_reset();
        do_reset("R1 reset state");
        set_rd(1'b1);
        for (int r = 0; r < N_REGS; r++) begin
            do_write(1'b0, r, DATA_W'(16'h1000 + r), 1'b0, "");
            do_write(1'b1, r, DATA_W'(16'h2000 + r), 1'b0, "");
        end
        #1 push_exp("R2 writes hidden before frame");
        do_write(1'b0, N_REGS + 3, 16'hDEAD, 1'b1, "R2 out-of-range write");
        do_frame("R3 load from bank A");
        do_write(1'b0, 3, 16'hAAAA, 1'b1, "R2 active-bank write hidden");
        do_write(1'b1, 3, 16'hBBBB, 1'b1, "R2 inactive-bank write ignored");
        do_write(1'b0, 0, 16'hA0A0, 1'b1, "R2 active early write hidden");
        do_frame("R3 active writes visible");
        // A -> B
        set_sel(1'b1);
        do_frame("R4 early group to B");
        do_frame("R5 others to B");
        do_write(1'b0, 7, 16'h7777, 1'b1, "R2 write to now-inactive A");
        do_frame("R3 steady in B");
        // B -> A
        set_sel(1'b0);
        do_frame("R6 early group back to A");
        do_frame("R6 others back to A");
        // Re-toggle before completion
        set_sel(1'b1);
        do_frame("R7 early to B");
        set_sel(1'b0);
        do_frame("R7 early back to A, others stay A");
        do_frame("R7 settled in A");
        // Select change while readout idle
        set_rd(1'b0);
        set_sel(1'b1);
        do_frame("R8 idle change not sampled");
        do_frame("R8 still A");
        set_rd(1'b1);
        do_frame("R8 early to B after resume");
        do_frame("R8 others to B after resume");
        do_reset("R1 reset mid-run");
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule